// File: doc/BRIEF.md
# Prescaled Hybrid Up Counter

This block is a free-running binary up counter with a count enable and no load input. The count is split into two sections. A narrow low section of `LOW_W` bits advances on every enabled clock. A wider high section of `HIGH_W` bits advances only when the low section is all ones and the enable is asserted. The high section's next value is formed by a plain bit-serial ripple carry.

The high section only takes a new value once every 2^`LOW_W` enabled counts, so its carry logic has that many clock periods to settle. Timing can then treat that chain as a multicycle path, and the fast clock only has to close over the short low section. The output is the concatenation of both sections and reads as an ordinary binary count, with no added latency.

Top module: `prescaled_counter`

## Requirements
- R1: While `rst_n` is low the counter is held at zero, and the first enabled edge after release yields a count of 1.
- R2: On a clock edge with `en` low, `count` does not change.
- R3: On a clock edge with `en` high, `count` becomes its previous value plus one, modulo 2^(`LOW_W`+`HIGH_W`).
- R4: The high field `count[LOW_W+HIGH_W-1:LOW_W]` changes only on an edge where `en` is high and the low field `count[LOW_W-1:0]` is all ones. On that edge it increments by one.
- R5: From the all-ones count, an enabled edge gives zero in both fields.
- R6: Each time the low field wraps from all ones to zero, the high field steps by exactly one, including across a carry that ripples through every high bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable, sampled on the rising edge |
| count | output | LOW_W+HIGH_W | Binary count, low field in the least significant `LOW_W` bits |

## Verification
The bench builds the counter with a 3-bit low section and a 5-bit high section, an 8-bit count of 256 states. That size lets a run pass through every count value, every low-field wrap and the full wrap back to zero in a few hundred cycles. Every value is compared against a reference count kept in the bench. Enable patterns that stop just before, on and just after the low-field terminal count show whether the high section steps only on the enabled carry edge. With 5 high bits, a carry into the top bit ripples through a chain long enough to expose a broken link anywhere in it.

// File: rtl/prescaled_counter.sv
module prescaled_counter #(
  parameter int LOW_W  = 3,
  parameter int HIGH_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  output logic [LOW_W+HIGH_W-1:0] count
);

  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;
  logic [HIGH_W-1:0] high_nxt;
  logic [HIGH_W:0]   rc;
  logic              low_tc;
  logic              high_step;

  assign low_tc    = &low_q;
  assign high_step = en & low_tc;

  // Ripple chain: settles over 2**LOW_W cycles before it is sampled.
  assign rc[0] = 1'b1;
  for (genvar i = 0; i < HIGH_W; i++) begin : g_ripple
    assign high_nxt[i] = high_q[i] ^ rc[i];
    assign rc[i+1]     = high_q[i] & rc[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (en) begin
      low_q <= low_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q <= '0;
    end else if (high_step) begin
      high_q <= high_nxt;
    end
  end

  assign count = {high_q, low_q};

endmodule

// File: rtl/prescaled_counter_chk.sv
module prescaled_counter_chk #(
  parameter int LOW_W  = 3,
  parameter int HIGH_W = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic [LOW_W+HIGH_W-1:0] count
);
  localparam int W = LOW_W + HIGH_W;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> count == W'($past(count) + 1'b1));

  a_r4_high_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && (&count[LOW_W-1:0])) |=> $stable(count[W-1:LOW_W]));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (&count)) |=> count == '0);

  a_r6_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (&count[LOW_W-1:0])) |=>
      count[W-1:LOW_W] == HIGH_W'($past(count[W-1:LOW_W]) + 1'b1));
endmodule

bind prescaled_counter prescaled_counter_chk #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .count(count)
);

// File: tb/prescaled_counter_tb.sv
module prescaled_counter_tb;
  localparam int PERIOD = 10;
  localparam int LW = 3;
  localparam int HW = 5;
  localparam int W  = LW + HW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] count;
  logic [W-1:0] exp_c;
  int           n_chk = 0;
  int           n_bad = 0;

  prescaled_counter #(.LOW_W(LW), .HIGH_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .count(count)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One edge with the given enable; checks full count and high field gating.
  task automatic step(logic e, string req);
    logic [HW-1:0] hi_before;
    logic          carry;
    hi_before = exp_c[W-1:LW];
    carry     = e && (&exp_c[LW-1:0]);
    en = e;
    @(posedge clk);
    @(negedge clk);
    if (e) exp_c = exp_c + 1'b1;
    check(req, count, exp_c);
    if (!carry) check("R4", {count[W-1:LW], {LW{1'b0}}}, {hi_before, {LW{1'b0}}});
    else        check("R6", {count[W-1:LW], {LW{1'b0}}}, {HW'(hi_before + 1'b1), {LW{1'b0}}});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    en = 1'b1;
    #(PERIOD*2);
    @(negedge clk);
    check("R1", count, '0);
    rst_n = 1'b1;
    exp_c = '0;
    step(1'b1, "R1");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++) step(1'b0, "R2");
  endtask

  task automatic t_full_run();
    for (int i = 0; i < (1 << W) + 3; i++) step(1'b1, ((&exp_c) ? "R5" : "R3"));
  endtask

  task automatic t_gated_edges();
    // Stop at each side of the low terminal count, then release.
    while (exp_c[LW-1:0] != {LW{1'b1}} - 1'b1) step(1'b1, "R3");
    step(1'b0, "R2");
    step(1'b1, "R3");
    step(1'b0, "R4");
    step(1'b0, "R4");
    step(1'b1, "R6");
    step(1'b0, "R2");
    for (int i = 0; i < 40; i++) step(i % 3 != 0, "R3");
  endtask

  task automatic t_long_ripple();
    // Walk to the point where the carry crosses every high bit.
    while (exp_c != {1'b0, {(W-1){1'b1}}}) step(1'b1, "R3");
    step(1'b0, "R4");
    step(1'b1, "R6");
    check("R6", count, {1'b1, {(W-1){1'b0}}});
  endtask

  task automatic t_async_reset();
    for (int i = 0; i < 5; i++) step(1'b1, "R3");
    #(PERIOD/4);
    rst_n = 1'b0;
    #(PERIOD/8);
    check("R1", count, '0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_c = '0;
    step(1'b1, "R1");
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: count=%0d expected=%0d", count, exp_c);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    exp_c = '0;
    t_reset();
    t_hold();
    t_full_run();
    t_gated_edges();
    t_long_ripple();
    t_async_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule